// File: doc/BRIEF.md
# TFT Raster Timing Generator

This block generates the raster timing a TFT panel needs, using one system clock. An even divider produces a pixel-clock enable and a pixel-clock pin. Two phase sequencers step through the horizontal and vertical intervals in a fixed order: sync, back porch, active, front porch. Every interval has a programmable length. The horizontal sequencer advances once per pixel period. The vertical sequencer advances once per completed line. The block drives horizontal sync, vertical sync, a data-enable strobe, an optional line-end pulse and a gated copy of the pixel data. Each of these outputs has its own polarity-invert control.

The block also reports status. Two-bit phase codes give the current horizontal and vertical interval, and a line counter runs down across the active lines of a frame. All configuration inputs are treated as static. They are copied into internal registers while the block is disabled and again at each frame boundary, so a frame never changes shape partway through.

Top module: `lcd_raster_gen`

## Requirements
- R1: The pixel period is 2*(clk_div+1) system clocks. `pix_ce` is high for exactly one clock in each period. `lcd_pclk` holds each level for clk_div+1 clocks.
- R2: The horizontal intervals repeat in the order sync, back porch, active, front porch. Their lengths in pixel periods are hsync_len+1, hback_len+1, hact_len+1 and hfront_len+1.
- R3: The vertical intervals repeat in the same order. Their lengths in lines are vsync_len+1, vback_len+1, vact_len+1 and vfront_len+1. The vertical interval changes only at the end of a horizontal front porch.
- R4: `h_phase` and `v_phase` report 2'b00 for sync, 2'b01 for back porch, 2'b10 for active and 2'b11 for front porch. Each change moves to the next code, modulo 4.
- R5: The active level of `lcd_hsync` covers exactly the horizontal sync interval, and the active level of `lcd_vsync` covers exactly the vertical sync interval. `lcd_den` is active when both directions are in the active interval. Each output is high when active if its invert bit is 0, and low when active if its invert bit is 1.
- R6: When `lend_en` is 1, `lcd_lend` is active for the first pixel period of each horizontal front porch. When `lend_en` is 0, it never goes active. `inv_lend` inverts its level.
- R7: `line_cnt` equals vact_len during vertical sync and back porch. During the active lines it counts down by one per line, reaching 0 on the last active line. It is 0 in the front porch. While the block is disabled it equals vact_len.
- R8: `lcd_data` equals `pix_data` while the data enable is active and zero otherwise. The whole word is inverted when `inv_data` is 1.
- R9: At the start of each pixel period, `lcd_pclk` is low when `rise_capture` is 1, so the capture edge is a rising edge in mid-period. It is high when `rise_capture` is 0, so the capture edge is a falling edge.
- R10: While `video_en` is 0, both phase codes are 00, `pix_ce` is 0, and every sync, enable, line-end and data output sits at its inactive level after inversion. `lcd_pclk` is held at its start-of-period level.
- R11: Timing fields changed while the block is enabled take effect only from the first sync line of the next frame.
- R12: A field value of zero gives an interval one period long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| video_en | input | 1 | Run enable; 0 holds the block idle |
| lend_en | input | 1 | Enables the line-end pulse |
| clk_div | input | DIV_W | Half-period length minus one, in system clocks |
| vsync_len | input | VSW_W | Vertical sync lines minus one |
| vback_len | input | VBP_W | Vertical back porch lines minus one |
| vact_len | input | VACT_W | Active lines minus one |
| vfront_len | input | VFP_W | Vertical front porch lines minus one |
| hsync_len | input | HSW_W | Horizontal sync pixels minus one |
| hback_len | input | HBP_W | Horizontal back porch pixels minus one |
| hact_len | input | HACT_W | Active pixels minus one |
| hfront_len | input | HFP_W | Horizontal front porch pixels minus one |
| inv_hsync | input | 1 | Inverts horizontal sync |
| inv_vsync | input | 1 | Inverts vertical sync |
| inv_den | input | 1 | Inverts data enable |
| inv_data | input | 1 | Inverts the data word |
| inv_lend | input | 1 | Inverts the line-end pulse |
| rise_capture | input | 1 | 1 = panel captures on rising edge, 0 = on falling edge |
| pix_data | input | DATA_W | Pixel word to present during active pixels |
| lcd_pclk | output | 1 | Pixel clock pin |
| pix_ce | output | 1 | One-clock strobe at the end of each pixel period |
| lcd_hsync | output | 1 | Horizontal sync |
| lcd_vsync | output | 1 | Vertical sync |
| lcd_den | output | 1 | Data enable |
| lcd_lend | output | 1 | Line-end pulse |
| lcd_data | output | DATA_W | Gated pixel data |
| h_phase | output | 2 | Horizontal interval code |
| v_phase | output | 2 | Vertical interval code |
| line_cnt | output | VACT_W | Down-counting active line counter |

## Verification
The assertions assume `clk_div` is at least 1. With that value, two pixel strobes can never fall in adjacent clocks, and the stimulus uses only divide values of 1 and 2. The assertions also assume that the enable stays steady for a cycle on each side of any phase step they judge. Checks at an enable transition are excluded by qualifying on the enable in both the current and the previous cycle. The bench changes polarity and edge-select inputs only while the block is disabled, and changes timing fields mid-frame only in the scenario built to show that they are deferred to the next frame.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;

    // Interval codes; the ordering is also the sequencing order.
    typedef enum logic [1:0] {
        PH_SYNC  = 2'b00,
        PH_BACK  = 2'b01,
        PH_ACT   = 2'b10,
        PH_FRONT = 2'b11
    } phase_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lcd_pclk_div.sv
module lcd_pclk_div #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_lim,
    output logic             pclk_raw,
    output logic             ce
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             lvl;
    } div_t;

    div_t st_d, st_q;
    logic half_end;

    always_comb begin
        half_end = (st_q.cnt >= half_lim);
        st_d     = st_q;
        if (!run) begin
            st_d = '0;
        end else if (half_end) begin
            st_d.cnt = '0;
            st_d.lvl = ~st_q.lvl;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // A period ends when the high half completes.
    assign ce       = run && half_end && st_q.lvl;
    assign pclk_raw = st_q.lvl;

endmodule

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq
    import lcd_raster_pkg::*;
#(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          step,
    input  logic [CW-1:0] lim_sync,
    input  logic [CW-1:0] lim_back,
    input  logic [CW-1:0] lim_act,
    input  logic [CW-1:0] lim_front,
    output phase_e        phase,
    output logic [CW-1:0] cnt,
    output logic          wrap
);
    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t          st_d, st_q;
    logic [CW-1:0] lim;
    logic          at_end;

    always_comb begin
        case (st_q.ph)
            PH_SYNC: lim = lim_sync;
            PH_BACK: lim = lim_back;
            PH_ACT:  lim = lim_act;
            default: lim = lim_front;
        endcase
        at_end = (st_q.cnt >= lim);
        st_d   = st_q;
        if (!run) begin
            st_d.ph  = PH_SYNC;
            st_d.cnt = '0;
        end else if (step) begin
            if (at_end) begin
                st_d.ph  = phase_e'(st_q.ph + 2'd1);
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph  <= PH_SYNC;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.ph;
    assign cnt   = st_q.cnt;
    assign wrap  = run && step && at_end && (st_q.ph == PH_FRONT);

endmodule

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen
    import lcd_raster_pkg::*;
#(
    parameter int DIV_W  = 10,
    parameter int VSW_W  = 6,
    parameter int VFP_W  = 8,
    parameter int VBP_W  = 8,
    parameter int VACT_W = 10,
    parameter int HFP_W  = 8,
    parameter int HSW_W  = 8,
    parameter int HBP_W  = 7,
    parameter int HACT_W = 11,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              video_en,
    input  logic              lend_en,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [VSW_W-1:0]  vsync_len,
    input  logic [VBP_W-1:0]  vback_len,
    input  logic [VACT_W-1:0] vact_len,
    input  logic [VFP_W-1:0]  vfront_len,
    input  logic [HSW_W-1:0]  hsync_len,
    input  logic [HBP_W-1:0]  hback_len,
    input  logic [HACT_W-1:0] hact_len,
    input  logic [HFP_W-1:0]  hfront_len,
    input  logic              inv_hsync,
    input  logic              inv_vsync,
    input  logic              inv_den,
    input  logic              inv_data,
    input  logic              inv_lend,
    input  logic              rise_capture,
    input  logic [DATA_W-1:0] pix_data,
    output logic              lcd_pclk,
    output logic              pix_ce,
    output logic              lcd_hsync,
    output logic              lcd_vsync,
    output logic              lcd_den,
    output logic              lcd_lend,
    output logic [DATA_W-1:0] lcd_data,
    output logic [1:0]        h_phase,
    output logic [1:0]        v_phase,
    output logic [VACT_W-1:0] line_cnt
);
    localparam int HCW = imax(imax(HSW_W, HBP_W), imax(HACT_W, HFP_W));
    localparam int VCW = imax(imax(VSW_W, VBP_W), imax(VACT_W, VFP_W));

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [VSW_W-1:0]  vsw;
        logic [VBP_W-1:0]  vbp;
        logic [VACT_W-1:0] vact;
        logic [VFP_W-1:0]  vfp;
        logic [HSW_W-1:0]  hsw;
        logic [HBP_W-1:0]  hbp;
        logic [HACT_W-1:0] hact;
        logic [HFP_W-1:0]  hfp;
        logic              lend_on;
        logic              inv_hs;
        logic              inv_vs;
        logic              inv_de;
        logic              inv_px;
        logic              inv_le;
        logic              rise;
    } cfg_t;

    cfg_t cfg_in, cfg_d, cfg_q;

    logic           pclk_raw;
    logic           ce;
    phase_e         h_ph, v_ph;
    logic [HCW-1:0] h_cnt;
    logic [VCW-1:0] v_cnt;
    logic           h_wrap, v_wrap;
    logic           den_raw, hs_raw, vs_raw, lend_raw;

    always_comb begin
        cfg_in         = '0;
        cfg_in.div     = clk_div;
        cfg_in.vsw     = vsync_len;
        cfg_in.vbp     = vback_len;
        cfg_in.vact    = vact_len;
        cfg_in.vfp     = vfront_len;
        cfg_in.hsw     = hsync_len;
        cfg_in.hbp     = hback_len;
        cfg_in.hact    = hact_len;
        cfg_in.hfp     = hfront_len;
        cfg_in.lend_on = lend_en;
        cfg_in.inv_hs  = inv_hsync;
        cfg_in.inv_vs  = inv_vsync;
        cfg_in.inv_de  = inv_den;
        cfg_in.inv_px  = inv_data;
        cfg_in.inv_le  = inv_lend;
        cfg_in.rise    = rise_capture;
    end

    // Configuration follows the inputs while idle and is re-sampled only
    // at the frame boundary while running.
    always_comb begin
        cfg_d = cfg_q;
        if (!video_en || v_wrap) cfg_d = cfg_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    lcd_pclk_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (video_en),
        .half_lim (cfg_q.div),
        .pclk_raw (pclk_raw),
        .ce       (ce)
    );

    lcd_phase_seq #(.CW(HCW)) u_hseq (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (video_en),
        .step      (ce),
        .lim_sync  (HCW'(cfg_q.hsw)),
        .lim_back  (HCW'(cfg_q.hbp)),
        .lim_act   (HCW'(cfg_q.hact)),
        .lim_front (HCW'(cfg_q.hfp)),
        .phase     (h_ph),
        .cnt       (h_cnt),
        .wrap      (h_wrap)
    );

    lcd_phase_seq #(.CW(VCW)) u_vseq (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (video_en),
        .step      (h_wrap),
        .lim_sync  (VCW'(cfg_q.vsw)),
        .lim_back  (VCW'(cfg_q.vbp)),
        .lim_act   (VCW'(cfg_q.vact)),
        .lim_front (VCW'(cfg_q.vfp)),
        .phase     (v_ph),
        .cnt       (v_cnt),
        .wrap      (v_wrap)
    );

    always_comb begin
        hs_raw   = video_en && (h_ph == PH_SYNC);
        vs_raw   = video_en && (v_ph == PH_SYNC);
        den_raw  = video_en && (h_ph == PH_ACT) && (v_ph == PH_ACT);
        lend_raw = video_en && cfg_q.lend_on && (h_ph == PH_FRONT) && (h_cnt == '0);
        case (v_ph)
            PH_ACT:   line_cnt = cfg_q.vact - VACT_W'(v_cnt);
            PH_FRONT: line_cnt = '0;
            default:  line_cnt = cfg_q.vact;
        endcase
    end

    assign lcd_hsync = hs_raw ^ cfg_q.inv_hs;
    assign lcd_vsync = vs_raw ^ cfg_q.inv_vs;
    assign lcd_den   = den_raw ^ cfg_q.inv_de;
    assign lcd_lend  = lend_raw ^ cfg_q.inv_le;
    assign lcd_data  = (den_raw ? pix_data : '0) ^ {DATA_W{cfg_q.inv_px}};
    assign lcd_pclk  = pclk_raw ^ ~cfg_q.rise;
    assign pix_ce    = ce;
    assign h_phase   = h_ph;
    assign v_phase   = v_ph;

endmodule

// File: rtl/lcd_raster_chk.sv
module lcd_raster_chk #(
    parameter int LC_W = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            video_en,
    input logic            pix_ce,
    input logic [1:0]      h_phase,
    input logic [1:0]      v_phase,
    input logic            den_raw,
    input logic [LC_W-1:0] line_cnt
);
    // R1: with a divide of at least 1 the strobes are never adjacent
    a_r1_ce_gap: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ce |=> !pix_ce);

    // R2: horizontal interval moves only after a pixel strobe
    a_r2_h_step_on_ce: assert property (@(posedge clk) disable iff (!rst_n)
        (video_en && $past(video_en) && h_phase != $past(h_phase)) |-> $past(pix_ce));

    // R4: horizontal code advances by one, modulo 4
    a_r4_h_order: assert property (@(posedge clk) disable iff (!rst_n)
        (video_en && $past(video_en) && h_phase != $past(h_phase))
            |-> h_phase == $past(h_phase) + 2'd1);

    // R3: vertical code advances by one, and only out of a horizontal front porch
    a_r3_v_order: assert property (@(posedge clk) disable iff (!rst_n)
        (video_en && $past(video_en) && v_phase != $past(v_phase))
            |-> (v_phase == $past(v_phase) + 2'd1) && ($past(h_phase) == 2'b11));

    // R5: the internal data enable lies inside both active intervals
    a_r5_den_inside_active: assert property (@(posedge clk) disable iff (!rst_n)
        den_raw |-> (h_phase == 2'b10) && (v_phase == 2'b10));

    // R7: the line counter never rises within a frame
    a_r7_line_cnt_down: assert property (@(posedge clk) disable iff (!rst_n)
        (video_en && $past(video_en) && v_phase != 2'b00) |-> line_cnt <= $past(line_cnt));

    // R10: disabling parks both sequencers and stops the strobe
    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !video_en |=> (h_phase == 2'b00) && (v_phase == 2'b00) && !pix_ce);

endmodule

bind lcd_raster_gen lcd_raster_chk #(.LC_W(VACT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .video_en (video_en),
    .pix_ce   (pix_ce),
    .h_phase  (h_phase),
    .v_phase  (v_phase),
    .den_raw  (den_raw),
    .line_cnt (line_cnt)
);

// File: tb/lcd_raster_gen_tb.sv
module lcd_raster_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG       = 100000;

    typedef struct {
        int div, hs, hb, ha, hf, vs, vb, vl, vf;
    } tcfg_t;

    tcfg_t cur, seen, expc;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic lend_en = 1'b1;
    logic inv_hs = 1'b0, inv_vs = 1'b0, inv_de = 1'b0, inv_px = 1'b0, inv_le = 1'b0;
    logic rise = 1'b1;
    logic [15:0] pix = 16'hA5C3;

    logic        lcd_pclk, pix_ce, lcd_hsync, lcd_vsync, lcd_den, lcd_lend;
    logic [15:0] lcd_data;
    logic [1:0]  h_phase, v_phase;
    logic [9:0]  line_cnt;

    int  n_chk = 0, n_fail = 0, cyc = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_raster_gen u_dut (
        .clk (clk), .rst_n (rst_n), .video_en (en), .lend_en (lend_en),
        .clk_div (10'(cur.div)),
        .vsync_len (6'(cur.vs)), .vback_len (8'(cur.vb)),
        .vact_len (10'(cur.vl)), .vfront_len (8'(cur.vf)),
        .hsync_len (8'(cur.hs)), .hback_len (7'(cur.hb)),
        .hact_len (11'(cur.ha)), .hfront_len (8'(cur.hf)),
        .inv_hsync (inv_hs), .inv_vsync (inv_vs), .inv_den (inv_de),
        .inv_data (inv_px), .inv_lend (inv_le), .rise_capture (rise),
        .pix_data (pix),
        .lcd_pclk (lcd_pclk), .pix_ce (pix_ce), .lcd_hsync (lcd_hsync),
        .lcd_vsync (lcd_vsync), .lcd_den (lcd_den), .lcd_lend (lcd_lend),
        .lcd_data (lcd_data), .h_phase (h_phase), .v_phase (v_phase),
        .line_cnt (line_cnt)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint ex);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, ex, $time);
        end
    endtask

    task automatic finish_test();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Configuration seen by the design at each edge
    always @(posedge clk) seen <= cur;

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
            finish_test();
        end
    end

    function automatic int hlim(input logic [1:0] p);
        case (p)
            2'd0: return expc.hs;
            2'd1: return expc.hb;
            2'd2: return expc.ha;
            default: return expc.hf;
        endcase
    endfunction

    function automatic int vlim(input logic [1:0] p);
        case (p)
            2'd0: return expc.vs;
            2'd1: return expc.vb;
            2'd2: return expc.vl;
            default: return expc.vf;
        endcase
    endfunction

    // Stream monitor
    bit         mon_on = 1'b0, first_h, first_v, first_p;
    logic [1:0] prev_h, prev_v;
    logic       prev_p;
    int         hrun, vrun, prun, idx;

    always @(negedge clk) begin
        int  per, lin;
        bit  hch, vch;
        bit  den_l, lend_l;
        if (mon_on) begin
            per = 2 * (expc.div + 1);
            lin = (expc.hs + expc.hb + expc.ha + expc.hf + 4) * per;
            hch = (h_phase != prev_h);
            vch = (v_phase != prev_v);
            if (lcd_pclk != prev_p) begin
                if (!first_p) chk(prun == expc.div + 1, "R1 pclk half period", prun, expc.div + 1);
                first_p = 1'b0;
                prun = 1;
            end else prun++;
            if (hch) begin
                if (!first_h) begin
                    // R2 and R12: interval length is field+1 pixel periods
                    chk(hrun == (hlim(prev_h) + 1) * per, "R2 h interval length", hrun, (hlim(prev_h) + 1) * per);
                    chk(h_phase == prev_h + 2'd1, "R4 h code order", h_phase, prev_h + 2'd1);
                end
                chk(lcd_pclk == !rise, "R9 pclk level at period start", lcd_pclk, !rise);
                first_h = 1'b0;
                hrun = 1;
            end else hrun++;
            if (vch) begin
                if (!first_v) begin
                    chk(vrun == (vlim(prev_v) + 1) * lin, "R3 v interval length", vrun, (vlim(prev_v) + 1) * lin);
                    chk(v_phase == prev_v + 2'd1, "R4 v code order", v_phase, prev_v + 2'd1);
                    chk(prev_h == 2'd3, "R3 v step from h front porch", prev_h, 3);
                end
                first_v = 1'b0;
                vrun = 1;
            end else vrun++;
            den_l  = (h_phase == 2'd2) && (v_phase == 2'd2);
            lend_l = lend_en && (h_phase == 2'd3) && (hrun <= per);
            chk(lcd_hsync == ((h_phase == 2'd0) ^ inv_hs), "R5 hsync", lcd_hsync, (h_phase == 2'd0) ^ inv_hs);
            chk(lcd_vsync == ((v_phase == 2'd0) ^ inv_vs), "R5 vsync", lcd_vsync, (v_phase == 2'd0) ^ inv_vs);
            chk(lcd_den == (den_l ^ inv_de), "R5 den", lcd_den, den_l ^ inv_de);
            chk(lcd_lend == (lend_l ^ inv_le), "R6 lend", lcd_lend, lend_l ^ inv_le);
            chk(lcd_data == ((den_l ? pix : 16'h0) ^ {16{inv_px}}), "R8 data", lcd_data,
                (den_l ? pix : 16'h0) ^ {16{inv_px}});
            // R11: new fields are adopted only on entry to the vertical sync
            if (vch && v_phase == 2'd0) expc = seen;
            if (vch && v_phase == 2'd2) idx = 0;
            if (hch && h_phase == 2'd0 && v_phase == 2'd2 && !vch) idx++;
            if (hch && h_phase == 2'd2 && v_phase == 2'd2)
                chk(line_cnt == 10'(expc.vl - idx), "R7 line counter", line_cnt, expc.vl - idx);
            prev_h = h_phase;
            prev_v = v_phase;
            prev_p = lcd_pclk;
        end
    end

    task automatic check_idle(input string tag);
        $display("idle check: %s", tag);
        chk(h_phase == 2'd0, "R10 h code idle", h_phase, 0);
        chk(v_phase == 2'd0, "R10 v code idle", v_phase, 0);
        chk(pix_ce == 1'b0, "R10 strobe idle", pix_ce, 0);
        chk(lcd_hsync == inv_hs, "R10 hsync idle", lcd_hsync, inv_hs);
        chk(lcd_vsync == inv_vs, "R10 vsync idle", lcd_vsync, inv_vs);
        chk(lcd_den == inv_de, "R10 den idle", lcd_den, inv_de);
        chk(lcd_lend == inv_le, "R10 lend idle", lcd_lend, inv_le);
        chk(lcd_data == {16{inv_px}}, "R10 data idle", lcd_data, {16{inv_px}});
        chk(lcd_pclk == !rise, "R10 pclk idle", lcd_pclk, !rise);
        chk(line_cnt == 10'(cur.vl), "R7 line counter idle", line_cnt, cur.vl);
    endtask

    task automatic start_run();
        @(posedge clk); #1;
        expc = cur;
        first_h = 1'b1; first_v = 1'b1; first_p = 1'b1;
        prev_h = h_phase; prev_v = v_phase; prev_p = lcd_pclk;
        hrun = 0; vrun = 0; prun = 0; idx = 0;
        en = 1'b1;
        mon_on = 1'b1;
    endtask

    task automatic stop_run(input string tag);
        @(posedge clk); #1;
        mon_on = 1'b0;
        en = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_idle(tag);
    endtask

    initial begin
        cur = '{div:1, hs:1, hb:2, ha:3, hf:1, vs:1, vb:1, vl:2, vf:0};
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_idle("after reset");

        // Normal polarity, rising capture, line-end on: frame 352 clocks
        start_run();
        repeat (3 * 352 + 20) @(posedge clk);
        stop_run("after normal run");

        // All inverted, falling capture, line-end off, zero-length fields (R12)
        @(posedge clk); #1;
        cur = '{div:2, hs:0, hb:0, ha:4, hf:0, vs:0, vb:0, vl:1, vf:0};
        inv_hs = 1'b1; inv_vs = 1'b1; inv_de = 1'b1; inv_px = 1'b1; inv_le = 1'b1;
        rise = 1'b0; lend_en = 1'b0; pix = 16'h3C96;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_idle("inverted idle");
        start_run();
        repeat (3 * 240 + 20) @(posedge clk);
        stop_run("after inverted run");

        // Mid-frame change of timing fields (R11)
        @(posedge clk); #1;
        cur = '{div:1, hs:1, hb:2, ha:3, hf:1, vs:1, vb:1, vl:2, vf:0};
        inv_hs = 1'b0; inv_vs = 1'b0; inv_de = 1'b0; inv_px = 1'b0; inv_le = 1'b0;
        rise = 1'b1; lend_en = 1'b1; pix = 16'h5A0F;
        repeat (4) @(posedge clk);
        start_run();
        repeat (352 + 100) @(posedge clk);
        #1;
        cur.ha = 5;
        cur.vb = 2;
        cur.div = 2;
        repeat (3 * 702 + 400) @(posedge clk);
        stop_run("after reconfigured run");

        finish_test();
    end

endmodule